// File: doc/BRIEF.md
# Edge-Triggered Up/Down Preset Counter

This block keeps a signed count that moves by one step for each rising edge seen on either of two level inputs, one for counting up and one for counting down. An input that is held high counts once, not once per clock. Software-free control logic of a larger chip uses it to track events against a signed target: one flag reports that the count has reached or passed the target, and another reports that it has fallen to zero or below.

Two level controls override counting. A clear input forces the count to zero, and a load input copies the preset into the count. Clear wins over load, and load wins over any edge. When rising edges arrive on both count inputs in the same cycle, they cancel. At the signed limits the count holds instead of wrapping. One width parameter yields every width variant.

Top module: `updn_counter`

## Requirements
- R1: A rising edge on `cntUp` (low at the previous clock edge, high at this one) raises `countVal` by one at that clock edge. Holding `cntUp` high adds no further counts.
- R2: A rising edge on `cntDown` lowers `countVal` by one at that clock edge. Holding `cntDown` high subtracts no further counts.
- R3: While `clrCount` is high at a clock edge, `countVal` becomes zero, whatever `loadPreset`, `presetVal` and the count inputs are doing.
- R4: While `loadPreset` is high and `clrCount` is low at a clock edge, `countVal` becomes `presetVal`, and edges on the count inputs in that cycle are ignored.
- R5: If rising edges arrive on both `cntUp` and `cntDown` at the same clock edge, `countVal` stays the same.
- R6: The count saturates. An up edge at the most positive value (2^(W-1)-1) leaves the count there, and a down edge at the most negative value (-2^(W-1)) leaves the count there.
- R7: `atPreset` is high exactly when `countVal` is greater than or equal to `presetVal`, with both read as two's-complement signed numbers.
- R8: `atOrBelowZero` is high exactly when `countVal`, read as a signed number, is less than or equal to zero.
- R9: Asynchronous active-low `rstN` sets `countVal` to zero and clears the stored history of both count inputs to low. So an input that is high when reset is released counts once at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntUp | input | 1 | Count-up level input; counts on its rising edges |
| cntDown | input | 1 | Count-down level input; counts on its rising edges |
| clrCount | input | 1 | Level input that forces the count to zero |
| loadPreset | input | 1 | Level input that copies the preset into the count |
| presetVal | input | W | Signed preset value |
| countVal | output | W | Current signed count |
| atPreset | output | 1 | Count is greater than or equal to the preset |
| atOrBelowZero | output | 1 | Count is less than or equal to zero |

## Verification
A stale or wrong edge-history bit shows up at the ports one clock after the input changes. The result is either a missing step or an extra step while an input is held high. The bench catches this by holding inputs across several edges and checking the count after each one. A wrong priority or saturation decision corrupts `countVal` at the very edge where the conflict occurs. Both flags follow the count with no register between them, so a wrong count or a wrong comparison shows on the flags in the same cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef struct packed {
    logic clear;
    logic load;
    logic inc;
    logic dec;
  } updnStrobe_t;
endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cntUp,
  input  logic        cntDown,
  input  logic        clrCount,
  input  logic        loadPreset,
  output updnStrobe_t strobe
);
  logic upPrev;
  logic downPrev;
  logic upEdge;
  logic downEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upPrev   <= 1'b0;
      downPrev <= 1'b0;
    end else begin
      upPrev   <= cntUp;
      downPrev <= cntDown;
    end
  end

  assign upEdge   = cntUp & ~upPrev;
  assign downEdge = cntDown & ~downPrev;

  always_comb begin
    strobe.clear = clrCount;
    strobe.load  = loadPreset & ~clrCount;
    strobe.inc   = upEdge & ~downEdge & ~clrCount & ~loadPreset;
    strobe.dec   = downEdge & ~upEdge & ~clrCount & ~loadPreset;
  end

  // R3/R4/R5: the datapath never receives two actions at once
  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clear, strobe.load, strobe.inc, strobe.dec}));
endmodule

// File: rtl/updn_dpath.sv
module updn_dpath
  import updn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  updnStrobe_t         strobe,
  input  logic signed [W-1:0] presetVal,
  output logic signed [W-1:0] countVal,
  output logic                atPreset,
  output logic                atOrBelowZero
);
  localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0] countQ;
  logic signed [W-1:0] countNext;

  always_comb begin
    countNext = countQ;
    if (strobe.clear)
      countNext = '0;
    else if (strobe.load)
      countNext = presetVal;
    else if (strobe.inc && countQ != MAX_V)
      countNext = countQ + 1'b1;
    else if (strobe.dec && countQ != MIN_V)
      countNext = countQ - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countNext;
  end

  assign countVal      = countQ;
  assign atPreset      = (countQ >= presetVal);
  assign atOrBelowZero = (countQ <= 0);

  assert_inc_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inc && countQ != MAX_V) |=> (countQ == $past(countQ) + 1'b1));

  assert_dec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && countQ != MIN_V) |=> (countQ == $past(countQ) - 1'b1));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (countQ == '0));

  assert_load_preset_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (countQ == $past(presetVal)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.clear || strobe.load || strobe.inc || strobe.dec) |=> $stable(countQ));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (countQ == MAX_V && !strobe.clear && !strobe.load && !strobe.dec) |=> (countQ == MAX_V));
endmodule

// File: rtl/updn_counter.sv
module updn_counter
  import updn_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cntUp,
  input  logic                cntDown,
  input  logic                clrCount,
  input  logic                loadPreset,
  input  logic signed [W-1:0] presetVal,
  output logic signed [W-1:0] countVal,
  output logic                atPreset,
  output logic                atOrBelowZero
);
  updnStrobe_t strobe;

  updn_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntUp      (cntUp),
    .cntDown    (cntDown),
    .clrCount   (clrCount),
    .loadPreset (loadPreset),
    .strobe     (strobe)
  );

  updn_dpath #(.W(W)) uDpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .presetVal     (presetVal),
    .countVal      (countVal),
    .atPreset      (atPreset),
    .atOrBelowZero (atOrBelowZero)
  );
endmodule

// File: tb/tb_updn_counter.sv
`timescale 1ns/1ps
module tb_updn_counter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cntUp = 1'b0;
  logic cntDown = 1'b0;
  logic clrCount = 1'b0;
  logic loadPreset = 1'b0;
  logic signed [W-1:0] presetVal = '0;
  logic signed [W-1:0] countVal;
  logic atPreset;
  logic atOrBelowZero;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  updn_counter #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .cntUp(cntUp), .cntDown(cntDown),
    .clrCount(clrCount), .loadPreset(loadPreset), .presetVal(presetVal),
    .countVal(countVal), .atPreset(atPreset), .atOrBelowZero(atOrBelowZero)
  );

  task automatic checkCount(input string req, input int expected);
    checks++;
    if (countVal !== W'(expected)) begin
      fails++;
      $display("FAIL %s count actual=%0d expected=%0d", req, countVal, expected);
    end
  endtask

  task automatic checkFlags(input string req, input logic expUp, input logic expDown);
    checks++;
    if (atPreset !== expUp || atOrBelowZero !== expDown) begin
      fails++;
      $display("FAIL %s flags actual=%b%b expected=%b%b", req,
               atPreset, atOrBelowZero, expUp, expDown);
    end
  endtask

  // inputs change at a falling edge; results are read at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulseUp();
    cntUp = 1'b1; step(); cntUp = 1'b0; step();
  endtask

  task automatic pulseDown();
    cntDown = 1'b1; step(); cntDown = 1'b0; step();
  endtask

  task automatic testReset();
    checkCount("R9 reset", 0);
    checkFlags("R7 R8 reset", 1'b1, 1'b1);
  endtask

  task automatic testUpEdge();
    presetVal = 8'sd3;
    cntUp = 1'b1;
    step(); checkCount("R1 first edge", 1);
    step(); step(); checkCount("R1 held level", 1);
    cntUp = 1'b0; step();
    pulseUp(); checkCount("R1 second edge", 2);
    checkFlags("R7 below preset", 1'b0, 1'b0);
    pulseUp(); checkFlags("R7 equal preset", 1'b1, 1'b0);
    presetVal = -8'sd2; #1; checkFlags("R7 negative preset", 1'b1, 1'b0);
    presetVal = 8'sd100; #1; checkFlags("R7 large preset", 1'b0, 1'b0);
  endtask

  task automatic testDownEdge();
    cntDown = 1'b1;
    step(); checkCount("R2 first edge", 2);
    step(); step(); checkCount("R2 held level", 2);
    cntDown = 1'b0; step();
    pulseDown(); pulseDown(); checkCount("R2 reach zero", 0);
    checkFlags("R8 zero", 1'b0, 1'b1);
    pulseDown(); checkCount("R2 negative", -1);
    checkFlags("R8 negative", 1'b0, 1'b1);
    pulseUp(); pulseUp(); checkFlags("R8 positive", 1'b0, 1'b0);
  endtask

  task automatic testBothEdges();
    cntUp = 1'b1; cntDown = 1'b1;
    step(); checkCount("R5 both edges cancel", 1);
    cntUp = 1'b0; cntDown = 1'b0; step();
    checkCount("R5 after release", 1);
  endtask

  task automatic testLoad();
    presetVal = 8'sd100; loadPreset = 1'b1; cntUp = 1'b1;
    step(); checkCount("R4 load beats edge", 100);
    loadPreset = 1'b0;
    step(); checkCount("R4 edge consumed during load", 100);
    checkFlags("R7 after load", 1'b1, 1'b0);
    cntUp = 1'b0; step();
  endtask

  task automatic testClear();
    presetVal = 8'sd50; loadPreset = 1'b1; clrCount = 1'b1; cntDown = 1'b1;
    step(); checkCount("R3 clear beats load and edge", 0);
    step(); checkCount("R3 clear held", 0);
    clrCount = 1'b0; loadPreset = 1'b0; cntDown = 1'b0; step();
    checkCount("R3 after release", 0);
  endtask

  task automatic testSaturate();
    presetVal = 8'sd127; loadPreset = 1'b1; step(); loadPreset = 1'b0;
    pulseUp(); checkCount("R6 hold at max", 127);
    pulseDown(); checkCount("R6 step down from max", 126);
    presetVal = -8'sd128; loadPreset = 1'b1; step(); loadPreset = 1'b0;
    pulseDown(); checkCount("R6 hold at min", -128);
    checkFlags("R7 R8 at min", 1'b1, 1'b1);
    pulseUp(); checkCount("R6 step up from min", -127);
  endtask

  task automatic testResetHistory();
    rstN = 1'b0; cntUp = 1'b1; step();
    checkCount("R9 count during reset", 0);
    rstN = 1'b1; step();
    checkCount("R9 edge after reset release", 1);
    step(); checkCount("R9 held after release", 1);
    cntUp = 1'b0; step();
  endtask

  initial begin
    repeat (2) step();
    rstN = 1'b1;
    step();
    testReset();
    testUpEdge();
    testDownEdge();
    testBothEdges();
    testLoad();
    testClear();
    testSaturate();
    testResetHistory();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule